// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switch Fabric

This block connects P message sources to P destinations through a multistage network of small two-by-two switches. Each source lane offers a valid flag, a destination index and a payload word. The message steers itself through log2(P) stages. Ahead of every stage the lanes are rewired by a perfect shuffle: lane i moves to the position given by rotating the bits of i one place to the left. Each switch then sets itself to straight or swapped from one destination bit. The first stage uses the most significant bit and each later stage uses the next lower bit.

The fabric is blocking. Two messages can reach the same switch and ask for the same switch output. In that case the message arriving on the even (lower) switch input goes on. The other message is dropped, and a blocked flag is raised for its source lane. Every stage ends in a pipeline register, so a full set of messages ("a wave") leaves the fabric log2(P) clock cycles after it enters. A new wave can enter on every cycle. Blocked messages are neither buffered nor retried.

Top module: `omega_net`

## Requirements
- R1: A valid message offered in cycle t appears at the outputs after exactly log2(P) rising clock edges. No output shows it earlier.
- R2: A delivered message appears on output lane `dst`. It carries its payload unchanged, and `out_src` holds its source lane index.
- R3: When no two valid messages meet at a switch wanting the same output, every valid message is delivered and no blocked flag is set. Examples are the identity pattern and a constant cyclic shift.
- R4: When two valid messages at a switch want the same output, the message on the even switch input is forwarded. This holds for the pair source 2 to destination 7 and source 6 to destination 4, where source 2 wins. It also holds for source 0 to destination 0 and source 4 to destination 1, where source 0 wins.
- R5: A dropped message is not delivered anywhere. `out_blocked[src]` is 1 in the same cycle its wave reaches the outputs, and 0 for every source that was delivered or idle.
- R6: With no valid input, all `out_valid` and `out_blocked` bits stay 0.
- R7: Waves offered on consecutive cycles leave on consecutive cycles, each routed as if alone.
- R8: While `rst_n` is low, `out_valid` and `out_blocked` are 0. Waves in flight when reset is applied are lost.
- R9: An input with `in_valid` low is never delivered and never blocks a valid message, whatever its destination field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | P | Per-source message present |
| in_dst | input | P*log2(P) | Per-source destination index; lane i at bits [i*log2(P) +: log2(P)] |
| in_data | input | P*W | Per-source payload; lane i at bits [i*W +: W] |
| out_valid | output | P | Per-destination message delivered |
| out_data | output | P*W | Delivered payload per destination lane |
| out_src | output | P*log2(P) | Source index of the delivered message per destination lane |
| out_blocked | output | P | Per-source flag: the message was dropped at a conflict |

## Verification
Delivery and blocking can occur in the same output cycle, because one wave can hold both winners and losers. This is provoked with conflict pairs and with a pattern where every source targets one destination. In each of these waves the winner must appear on its destination lane with the correct payload and source index. In the same cycle the loser's blocked bit must be set, and the loser must appear on no lane. Results are compared with a stage-by-stage routing model in the bench and, for the two named pairs, with values fixed by hand.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic {
    SW_PASS  = 1'b0,
    SW_CROSS = 1'b1
  } sw_mode_e;

  // Left rotation of a lane index over a field of the given width.
  function automatic int unsigned rotl_idx(int unsigned idx, int unsigned bits);
    int unsigned top;
    top = (idx >> (bits - 1)) & 1;
    return ((idx << 1) & ((1 << bits) - 1)) | top;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int N   = 3,
  parameter int W   = 16,
  parameter int BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_v,
  input  logic [N-1:0] a_dst,
  input  logic [N-1:0] a_src,
  input  logic [W-1:0] a_dat,
  input  logic         b_v,
  input  logic [N-1:0] b_dst,
  input  logic [N-1:0] b_src,
  input  logic [W-1:0] b_dat,
  output logic         y0_v,
  output logic [N-1:0] y0_dst,
  output logic [N-1:0] y0_src,
  output logic [W-1:0] y0_dat,
  output logic         y1_v,
  output logic [N-1:0] y1_dst,
  output logic [N-1:0] y1_src,
  output logic [W-1:0] y1_dat,
  output logic         drop_v,
  output logic [N-1:0] drop_src
);

  sw_mode_e mode;
  logic     a_port, b_port, clash, b_go;

  always_comb begin
    a_port = a_dst[BIT];
    b_port = b_dst[BIT];
    clash  = a_v && b_v && (a_port == b_port);
    b_go   = b_v && !clash;
    // The even input sets the mode whenever it carries a message.
    if (a_v)      mode = a_port ? SW_CROSS : SW_PASS;
    else if (b_v) mode = b_port ? SW_PASS  : SW_CROSS;
    else          mode = SW_PASS;
  end

  always_comb begin
    if (mode == SW_PASS) begin
      y0_v = a_v;  y0_dst = a_dst; y0_src = a_src; y0_dat = a_dat;
      y1_v = b_go; y1_dst = b_dst; y1_src = b_src; y1_dat = b_dat;
    end else begin
      y0_v = b_go; y0_dst = b_dst; y0_src = b_src; y0_dat = b_dat;
      y1_v = a_v;  y1_dst = a_dst; y1_src = a_src; y1_dat = a_dat;
    end
    drop_v   = clash;
    drop_src = b_src;
  end

  // R2: switch setting agrees with the source/destination bit comparison
  p_mode_rule_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_v |-> ((mode == SW_CROSS) == (a_src[BIT] != a_dst[BIT])));
  p_mode_rule_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (b_v && !a_v) |-> ((mode == SW_CROSS) == (b_src[BIT] != b_dst[BIT])));

  // R4: on a clash the even-input message leaves on one of the outputs
  p_low_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_v && b_v && (a_dst[BIT] == b_dst[BIT])) |->
      ((y0_v && y0_src == a_src) || (y1_v && y1_src == a_src)));

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int P   = 8,
  parameter int N   = 3,
  parameter int W   = 16,
  parameter int STG = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] in_v,
  input  logic [N-1:0] in_dst [P],
  input  logic [N-1:0] in_src [P],
  input  logic [W-1:0] in_dat [P],
  input  logic [P-1:0] in_blk,
  output logic [P-1:0] q_v,
  output logic [N-1:0] q_dst  [P],
  output logic [N-1:0] q_src  [P],
  output logic [W-1:0] q_dat  [P],
  output logic [P-1:0] q_blk
);

  localparam int HALF = P / 2;
  localparam int BIT  = N - 1 - STG;
  localparam int PW   = STG + 1;

  logic [P-1:0] sh_v;
  logic [N-1:0] sh_dst [P];
  logic [N-1:0] sh_src [P];
  logic [W-1:0] sh_dat [P];

  logic [P-1:0] nx_v;
  logic [N-1:0] nx_dst [P];
  logic [N-1:0] nx_src [P];
  logic [W-1:0] nx_dat [P];
  logic [P-1:0] nx_blk;

  logic [HALF-1:0] drop_v;
  logic [N-1:0]    drop_src [HALF];

  // Perfect shuffle wiring ahead of the switch column.
  for (genvar i = 0; i < P; i++) begin : g_shuffle
    localparam int unsigned TO = rotl_idx(i, N);
    assign sh_v[TO]   = in_v[i];
    assign sh_dst[TO] = in_dst[i];
    assign sh_src[TO] = in_src[i];
    assign sh_dat[TO] = in_dat[i];
  end

  for (genvar k = 0; k < HALF; k++) begin : g_sw
    omega_switch #(.N(N), .W(W), .BIT(BIT)) u_sw (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_v     (sh_v[2*k]),
      .a_dst   (sh_dst[2*k]),
      .a_src   (sh_src[2*k]),
      .a_dat   (sh_dat[2*k]),
      .b_v     (sh_v[2*k+1]),
      .b_dst   (sh_dst[2*k+1]),
      .b_src   (sh_src[2*k+1]),
      .b_dat   (sh_dat[2*k+1]),
      .y0_v    (nx_v[2*k]),
      .y0_dst  (nx_dst[2*k]),
      .y0_src  (nx_src[2*k]),
      .y0_dat  (nx_dat[2*k]),
      .y1_v    (nx_v[2*k+1]),
      .y1_dst  (nx_dst[2*k+1]),
      .y1_src  (nx_src[2*k+1]),
      .y1_dat  (nx_dat[2*k+1]),
      .drop_v  (drop_v[k]),
      .drop_src(drop_src[k])
    );
  end

  // Next state of the per-source blocked mask.
  always_comb begin
    nx_blk = in_blk;
    for (int k = 0; k < HALF; k++) begin
      if (drop_v[k]) nx_blk[drop_src[k]] = 1'b1;
    end
  end

  // Control registers: reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v   <= '0;
      q_blk <= '0;
    end else begin
      q_v   <= nx_v;
      q_blk <= nx_blk;
    end
  end

  // Datapath registers: no reset, loaded only when the lane carries a message.
  always_ff @(posedge clk) begin
    for (int j = 0; j < P; j++) begin
      if (nx_v[j]) begin
        q_dst[j] <= nx_dst[j];
        q_src[j] <= nx_src[j];
        q_dat[j] <= nx_dat[j];
      end
    end
  end

  // R2: after this stage the low lane-index bits match the used destination bits
  for (genvar j = 0; j < P; j++) begin : g_chk
    localparam int JP = j % (1 << PW);
    p_lane_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_v[j] |-> (q_dst[j][N-1 -: PW] == PW'(JP)));
  end

  // R4/R5: every message entering a stage either leaves it or is flagged blocked
  p_conserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      ($countones(q_v) + $countones(q_blk) ==
       $past($countones(in_v) + $countones(in_blk))));

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int P = 8,
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [P-1:0]              in_valid,
  input  logic [P*$clog2(P)-1:0]    in_dst,
  input  logic [P*W-1:0]            in_data,
  output logic [P-1:0]              out_valid,
  output logic [P*W-1:0]            out_data,
  output logic [P*$clog2(P)-1:0]    out_src,
  output logic [P-1:0]              out_blocked
);

  localparam int N = $clog2(P);

  logic [1:0] rst_sync;
  logic       rst_q_n;

  logic [P-1:0] v_c   [N+1];
  logic [N-1:0] dst_c [N+1][P];
  logic [N-1:0] src_c [N+1][P];
  logic [W-1:0] dat_c [N+1][P];
  logic [P-1:0] blk_c [N+1];

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // Unpack the flat input lanes.
  assign v_c[0]   = in_valid;
  assign blk_c[0] = '0;
  for (genvar i = 0; i < P; i++) begin : g_in
    assign dst_c[0][i] = in_dst[i*N +: N];
    assign src_c[0][i] = N'(i);
    assign dat_c[0][i] = in_data[i*W +: W];
  end

  for (genvar s = 0; s < N; s++) begin : g_stage
    omega_stage #(.P(P), .N(N), .W(W), .STG(s)) u_stage (
      .clk   (clk),
      .rst_n (rst_q_n),
      .in_v  (v_c[s]),
      .in_dst(dst_c[s]),
      .in_src(src_c[s]),
      .in_dat(dat_c[s]),
      .in_blk(blk_c[s]),
      .q_v   (v_c[s+1]),
      .q_dst (dst_c[s+1]),
      .q_src (src_c[s+1]),
      .q_dat (dat_c[s+1]),
      .q_blk (blk_c[s+1])
    );
  end

  assign out_valid   = v_c[N];
  assign out_blocked = blk_c[N];
  for (genvar j = 0; j < P; j++) begin : g_out
    assign out_data[j*W +: W] = dat_c[N][j];
    assign out_src[j*N +: N]  = src_c[N][j];

    // R2: a delivered message sits on the lane named by its destination
    p_dest_match_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
      out_valid[j] |-> (dst_c[N][j] == N'(j)));

    // R5: a source is never both delivered and blocked in one wave
    p_no_dual_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
      out_valid[j] |-> !out_blocked[src_c[N][j]]);
  end

endmodule

// File: tb/omega_net_test.sv
`timescale 1ns/1ps
module omega_net_test;

  localparam int P = 8;
  localparam int W = 16;
  localparam int N = $clog2(P);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [P-1:0]   in_valid;
  logic [P*N-1:0] in_dst;
  logic [P*W-1:0] in_data;
  logic [P-1:0]   out_valid;
  logic [P*W-1:0] out_data;
  logic [P*N-1:0] out_src;
  logic [P-1:0]   out_blocked;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  omega_net #(.P(P), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_src(out_src), .out_blocked(out_blocked)
  );

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Stage-by-stage routing model built from the requirements.
  task automatic model(input logic [P-1:0] v, input logic [P*N-1:0] d,
                       input logic [P*W-1:0] x,
                       output logic [P-1:0] ev, output logic [P*W-1:0] ex,
                       output logic [P*N-1:0] es, output logic [P-1:0] eb);
    int pos [P];
    int npos [P];
    bit alive [P];
    bit lose [P];
    for (int i = 0; i < P; i++) begin pos[i] = i; alive[i] = v[i]; end
    for (int s = 0; s < N; s++) begin
      for (int i = 0; i < P; i++) begin
        pos[i]  = ((pos[i] << 1) & (P - 1)) | (pos[i] >> (N - 1));
        npos[i] = (pos[i] & ~1) | int'(d[i*N + (N-1-s)]);
        lose[i] = 1'b0;
      end
      for (int i = 0; i < P; i++)
        for (int k = 0; k < P; k++)
          if (i != k && alive[i] && alive[k] && npos[i] == npos[k] && (pos[i] % 2) == 1)
            lose[i] = 1'b1;
      for (int i = 0; i < P; i++) begin
        if (lose[i]) alive[i] = 1'b0;
        pos[i] = npos[i];
      end
    end
    ev = '0; ex = '0; es = '0; eb = '0;
    for (int i = 0; i < P; i++) begin
      if (alive[i]) begin
        ev[pos[i]] = 1'b1;
        ex[pos[i]*W +: W] = x[i*W +: W];
        es[pos[i]*N +: N] = N'(i);
      end
      eb[i] = v[i] && !alive[i];
    end
  endtask

  task automatic compare(string req, logic [P-1:0] ev, logic [P*W-1:0] ex,
                         logic [P*N-1:0] es, logic [P-1:0] eb);
    logic [P*W-1:0] md;
    logic [P*N-1:0] ms;
    for (int j = 0; j < P; j++) begin
      md[j*W +: W] = ev[j] ? out_data[j*W +: W] : '0;
      ms[j*N +: N] = ev[j] ? out_src[j*N +: N]  : '0;
    end
    check(req, "out_valid",   128'(out_valid),   128'(ev));
    check(req, "out_blocked", 128'(out_blocked), 128'(eb));
    check(req, "out_data",    128'(md),          128'(ex));
    check(req, "out_src",     128'(ms),          128'(es));
  endtask

  // One wave in, sampled after N rising edges.
  task automatic run_wave(string req, logic [P-1:0] v, logic [P*N-1:0] d, logic [P*W-1:0] x);
    logic [P-1:0] ev, eb;
    logic [P*W-1:0] ex;
    logic [P*N-1:0] es;
    model(v, d, x, ev, ex, es, eb);
    @(negedge clk);
    in_valid = v; in_dst = d; in_data = x;
    @(negedge clk);
    in_valid = '0;
    check(req, "no early output", 128'(out_valid | out_blocked), 128'(0));
    repeat (N - 1) @(negedge clk);
    compare(req, ev, ex, es, eb);
  endtask

  function automatic logic [P*W-1:0] pat(int seed);
    logic [P*W-1:0] r;
    for (int i = 0; i < P; i++) r[i*W +: W] = W'(16'h1000 * seed + 16'h0101 * i + 3);
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; in_valid = '0; in_dst = '0; in_data = '0;
    repeat (3) @(negedge clk);
    check("R8", "valid in reset",   128'(out_valid),   128'(0));
    check("R8", "blocked in reset", 128'(out_blocked), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_identity();
    logic [P*N-1:0] d;
    for (int i = 0; i < P; i++) d[i*N +: N] = N'(i);
    run_wave("R1 R2 R3 identity", '1, d, pat(1));
  endtask

  task automatic t_shift();
    logic [P*N-1:0] d;
    for (int i = 0; i < P; i++) d[i*N +: N] = N'(i + 3);
    run_wave("R3 shift", '1, d, pat(2));
    check("R3", "no blocking on shift", 128'(out_blocked), 128'(0));
  endtask

  task automatic t_pair_a();
    logic [P*N-1:0] d = '0;
    logic [P-1:0] v = '0;
    logic [P*W-1:0] x = pat(3);
    v[2] = 1'b1; d[2*N +: N] = 3'd7;
    v[6] = 1'b1; d[6*N +: N] = 3'd4;
    run_wave("R4 R5 pair 2/6", v, d, x);
    check("R4", "winner lane 7", 128'(out_valid), 128'(8'b1000_0000));
    check("R5", "loser src 6",   128'(out_blocked), 128'(8'b0100_0000));
    check("R2", "payload lane 7", 128'(out_data[7*W +: W]), 128'(x[2*W +: W]));
  endtask

  task automatic t_pair_b();
    logic [P*N-1:0] d = '0;
    logic [P-1:0] v = '0;
    v[0] = 1'b1; d[0*N +: N] = 3'd0;
    v[4] = 1'b1; d[4*N +: N] = 3'd1;
    run_wave("R4 R5 pair 0/4", v, d, pat(4));
    check("R4", "winner lane 0", 128'(out_valid),   128'(8'b0000_0001));
    check("R5", "loser src 4",   128'(out_blocked), 128'(8'b0001_0000));
  endtask

  task automatic t_hotspot();
    logic [P*N-1:0] d;
    for (int i = 0; i < P; i++) d[i*N +: N] = 3'd5;
    run_wave("R4 R5 hotspot", '1, d, pat(5));
    check("R5", "one delivered", 128'($countones(out_valid)), 128'(1));
  endtask

  task automatic t_idle();
    logic [P*N-1:0] d;
    for (int i = 0; i < P; i++) d[i*N +: N] = N'(7 - i);
    run_wave("R6 idle", '0, d, pat(6));
  endtask

  task automatic t_invalid();
    logic [P*N-1:0] d = '0;
    logic [P-1:0] v = '0;
    d[0*N +: N] = 3'd0;
    v[4] = 1'b1; d[4*N +: N] = 3'd1;
    run_wave("R9 invalid", v, d, pat(7));
    check("R9", "src 4 reaches lane 1", 128'(out_valid),   128'(8'b0000_0010));
    check("R9", "nothing blocked",      128'(out_blocked), 128'(0));
  endtask

  task automatic t_pipeline();
    logic [P-1:0]   wv [3];
    logic [P*N-1:0] wd [3];
    logic [P*W-1:0] wx [3];
    logic [P-1:0]   ev [3];
    logic [P-1:0]   eb [3];
    logic [P*W-1:0] ex [3];
    logic [P*N-1:0] es [3];
    for (int w = 0; w < 3; w++) begin
      wv[w] = (w == 1) ? 8'b1111_0000 : '1;
      for (int i = 0; i < P; i++) wd[w][i*N +: N] = N'(i * (w + 1) + w);
      wx[w] = pat(8 + w);
      model(wv[w], wd[w], wx[w], ev[w], ex[w], es[w], eb[w]);
    end
    for (int c = 0; c <= N + 2; c++) begin
      @(negedge clk);
      if (c >= N && c - N < 3) compare("R7 back-to-back", ev[c-N], ex[c-N], es[c-N], eb[c-N]);
      if (c < 3) begin in_valid = wv[c]; in_dst = wd[c]; in_data = wx[c]; end
      else in_valid = '0;
    end
  endtask

  task automatic t_reset_flight();
    @(negedge clk);
    in_valid = '1;
    for (int i = 0; i < P; i++) in_dst[i*N +: N] = N'(i);
    @(negedge clk);
    in_valid = '0;
    rst_n = 1'b0;
    #1;
    check("R8", "in-flight cleared", 128'(out_valid | out_blocked), 128'(0));
    repeat (N + 1) @(negedge clk);
    check("R8", "still clear", 128'(out_valid | out_blocked), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", "clear after release", 128'(out_valid | out_blocked), 128'(0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_identity();
    t_shift();
    t_pair_a();
    t_pair_b();
    t_hotspot();
    t_idle();
    t_invalid();
    t_pipeline();
    t_reset_flight();
    t_identity();
    finish_run();
  end

endmodule